// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits beside the receive datapath and decides, for each incoming frame, whether the frame is kept. The datapath streams the first bytes of the frame in, one byte per cycle. A start-of-frame flag marks the first destination byte. Once all six destination bytes have arrived, the filter issues a single-cycle decision. The decision reports whether the frame is accepted, whether one of the exact-match slots recognised the address, and whether the address was broadcast or multicast.

Acceptance is the OR of four independent paths. The first is a bank of exact-match slots. Each slot has its own valid bit and a 48-bit address. The second is an all-ones broadcast gate. The third is a multicast gate that looks up a 64-entry hash table, indexed by a 6-bit fold of the address. The fourth is a promiscuous override that accepts everything. The three mode enables sit in a small option register, loaded by a strobe. The hash table is held inside the block and written one entry at a time.

The input stream has a ready signal for form's sake. The filter never applies back-pressure: `in_ready` is high in every cycle, including during reset. Any beat with `in_valid` high is therefore consumed. The decision output has no ready and must be taken in the cycle it is shown.

Top module: `eth_da_filter`

## Requirements
- R1: The beat carrying `in_sof` supplies destination octet 0, which lands in address bits 7:0. Octet k lands in bits 8k+7:8k. Cycles with `in_valid` low are skipped. Beats after the sixth octet, and beats with no start seen yet, are ignored until the next `in_sof`.
- R2: `dec_valid` is high for exactly one cycle: the cycle after the clock edge that consumes the sixth octet. It is low at all other times.
- R3: A beat with `in_sof` high throws away any octets already gathered and restarts collection with its own byte as octet 0.
- R4: Slot i, given by `slot_addr[48i+47:48i]` and `slot_valid[i]`, hits when its valid bit is set and its address equals the destination. On any hit, `dec_slot_hit` is 1, the frame is accepted and `dec_slot_idx` is the lowest hitting index. With no hit, `dec_slot_idx` is 0.
- R5: A slot whose address is all zeros never hits, even with its valid bit set. A slot whose valid bit is clear never hits either.
- R6: When the promiscuous option is on, every decision has `dec_accept` = 1.
- R7: The address FF:FF:FF:FF:FF:FF sets `dec_is_bcast`. It is accepted through the broadcast gate only while the broadcast option is on.
- R8: An address is multicast (`dec_is_mcast`) when bit 0 of octet 0 is 1 and the address is not broadcast. The hash index has 6 bits; index bit i is the XOR of address bits i, i+6, ..., i+42. A multicast frame passes this gate only when the multicast option is on and the table entry at that index is 1.
- R9: The hash table is all zeros after reset. A cycle with `hash_wr` high sets entry `hash_idx` to `hash_bit` from the next cycle on, and leaves every other entry unchanged.
- R10: A cycle with `opt_load` high copies `opt_promisc`, `opt_bcast` and `opt_mcast` into the option register. After reset the register holds promiscuous off, broadcast on and multicast off.
- R11: `in_ready` is 1 in every cycle.
- R12: A destination that hits no slot and passes no gate is rejected (`dec_accept` = 0), and `dec_valid` still pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte beat present |
| in_ready | output | 1 | Always 1; the filter never stalls |
| in_sof | input | 1 | This beat is destination octet 0 |
| in_data | input | 8 | Destination octet |
| opt_load | input | 1 | Load the three option bits |
| opt_promisc | input | 1 | Promiscuous value to load |
| opt_bcast | input | 1 | Broadcast-enable value to load |
| opt_mcast | input | 1 | Multicast-hash-enable value to load |
| hash_wr | input | 1 | Write one hash table entry |
| hash_idx | input | 6 | Hash entry to write |
| hash_bit | input | 1 | Value written to the entry |
| slot_valid | input | 4 | Per-slot valid bits |
| slot_addr | input | 192 | Four 48-bit slot addresses, slot i at bits 48i+47:48i |
| dec_valid | output | 1 | One-cycle decision strobe |
| dec_accept | output | 1 | Frame accepted |
| dec_slot_hit | output | 1 | Some exact-match slot hit |
| dec_slot_idx | output | 2 | Lowest hitting slot |
| dec_is_bcast | output | 1 | Destination was broadcast |
| dec_is_mcast | output | 1 | Destination was multicast |

## Verification
The assertions take `slot_addr` and `slot_valid` as steady while a frame's address is being collected. The comparison uses them only in the cycle of the sixth octet. The single-cycle decision pulse also relies on at least six beats between decisions, which is how the collection counter works. The bench therefore changes slot settings, options and hash entries only while no address is in flight, and then lets one idle cycle pass. It drives the octets with deliberate gaps, trailing payload bytes and aborted starts, so that the skip and restart rules are exercised without ever violating those assumptions.

// File: rtl/eth_da_pkg.sv
package eth_da_pkg;
  localparam int unsigned OCTET_W    = 8;
  localparam int unsigned DA_OCTETS  = 6;
  localparam int unsigned DA_W       = OCTET_W * DA_OCTETS;
  localparam int unsigned HASH_IDX_W = 6;

  typedef logic [DA_W-1:0] mac_addr_t;

  typedef struct packed {
    logic promisc;
    logic bcast_en;
    logic mcast_en;
  } filt_opts_t;

  localparam filt_opts_t OPTS_RESET = '{promisc: 1'b0, bcast_en: 1'b1, mcast_en: 1'b0};
endpackage

// File: rtl/da_collector.sv
module da_collector #(
  parameter int unsigned OCTET_W   = 8,
  parameter int unsigned DA_OCTETS = 6
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          beat,
  input  logic                          sof,
  input  logic [OCTET_W-1:0]            data,
  output logic                          full,
  output logic [OCTET_W*DA_OCTETS-1:0]  addr_full
);
  localparam int unsigned ADDR_W = OCTET_W * DA_OCTETS;
  localparam int unsigned CNT_W  = $clog2(DA_OCTETS + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DA_OCTETS - 1);
  localparam logic [CNT_W-1:0] DONE_CNT = CNT_W'(DA_OCTETS);

  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q;

  always_comb begin
    full      = beat && !sof && (cnt_q == LAST_CNT);
    addr_full = addr_q;
    addr_full[ADDR_W-1 -: OCTET_W] = data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      addr_q <= '0;
    end else if (beat) begin
      if (sof) begin
        cnt_q                <= CNT_W'(1);
        addr_q[OCTET_W-1:0]  <= data;
      end else if (cnt_q != '0 && cnt_q != DONE_CNT) begin
        cnt_q                                  <= cnt_q + CNT_W'(1);
        addr_q[int'(cnt_q)*OCTET_W +: OCTET_W] <= data;
      end
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= DONE_CNT); // R1
  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && sof) |=> (cnt_q == CNT_W'(1))); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |=> $stable(cnt_q)); // R1
endmodule

// File: rtl/da_slot_match.sv
module da_slot_match #(
  parameter int unsigned N_SLOTS = 4,
  parameter int unsigned ADDR_W  = 48,
  parameter int unsigned IDX_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           da,
  input  logic [N_SLOTS-1:0]          slot_valid,
  input  logic [N_SLOTS*ADDR_W-1:0]   slot_addr,
  output logic                        hit_any,
  output logic [IDX_W-1:0]            hit_idx
);
  logic [N_SLOTS-1:0] hit;

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] ref_addr;
    logic              live;
    assign ref_addr = slot_addr[s*ADDR_W +: ADDR_W];
    assign live     = slot_valid[s] && (ref_addr != '0);
    assign hit[s]   = live && (ref_addr == da);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N_SLOTS - 1; i >= 0; i--) begin
      if (hit[i]) hit_idx = IDX_W'(i);
    end
    hit_any = |hit;
  end

  AST_HIT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_any |-> (slot_valid[hit_idx] && da != '0)); // R5
endmodule

// File: rtl/da_hash_gate.sv
module da_hash_gate #(
  parameter int unsigned ADDR_W     = 48,
  parameter int unsigned HASH_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [HASH_IDX_W-1:0] wr_idx,
  input  logic                  wr_bit,
  input  logic [ADDR_W-1:0]     da,
  input  logic                  mcast_en,
  output logic                  is_bcast,
  output logic                  is_mcast,
  output logic                  hash_hit
);
  localparam int unsigned N_ENT = 1 << HASH_IDX_W;

  logic [N_ENT-1:0]      table_q;
  logic [HASH_IDX_W-1:0] idx;

  for (genvar b = 0; b < HASH_IDX_W; b++) begin : g_fold
    logic fold_bit;
    always_comb begin
      fold_bit = 1'b0;
      for (int j = b; j < ADDR_W; j += HASH_IDX_W) fold_bit ^= da[j];
    end
    assign idx[b] = fold_bit;
  end

  always_comb begin
    is_bcast = &da;
    is_mcast = da[0] && !is_bcast;
    hash_hit = mcast_en && is_mcast && table_q[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) table_q <= '0;
    else if (wr_en) table_q[wr_idx] <= wr_bit;
  end

  AST_HASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_bit) |=> !table_q[$past(wr_idx)]); // R9
  AST_HASH_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_bit) |=> table_q[$past(wr_idx)]); // R9
  AST_HASH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!mcast_en || !da[0]) |-> !hash_hit); // R8
endmodule

// File: rtl/eth_da_filter.sv
module eth_da_filter
  import eth_da_pkg::*;
#(
  parameter int unsigned N_SLOTS = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic                            in_sof,
  input  logic [OCTET_W-1:0]              in_data,
  input  logic                            opt_load,
  input  logic                            opt_promisc,
  input  logic                            opt_bcast,
  input  logic                            opt_mcast,
  input  logic                            hash_wr,
  input  logic [HASH_IDX_W-1:0]           hash_idx,
  input  logic                            hash_bit,
  input  logic [N_SLOTS-1:0]              slot_valid,
  input  logic [N_SLOTS*DA_W-1:0]         slot_addr,
  output logic                            dec_valid,
  output logic                            dec_accept,
  output logic                            dec_slot_hit,
  output logic [((N_SLOTS > 1) ? $clog2(N_SLOTS) : 1)-1:0] dec_slot_idx,
  output logic                            dec_is_bcast,
  output logic                            dec_is_mcast
);
  localparam int unsigned SLOT_IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

  filt_opts_t            opts_q;
  logic                  beat;
  logic                  da_full;
  mac_addr_t             da;
  logic                  hit_any;
  logic [SLOT_IDX_W-1:0] hit_idx;
  logic                  is_bcast, is_mcast, hash_hit;
  logic                  accept_now;

  assign in_ready = 1'b1;
  assign beat     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) opts_q <= OPTS_RESET;
    else if (opt_load) opts_q <= '{promisc: opt_promisc, bcast_en: opt_bcast, mcast_en: opt_mcast};
  end

  da_collector #(.OCTET_W(OCTET_W), .DA_OCTETS(DA_OCTETS)) u_collect (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sof(in_sof), .data(in_data),
    .full(da_full), .addr_full(da)
  );

  da_slot_match #(.N_SLOTS(N_SLOTS), .ADDR_W(DA_W), .IDX_W(SLOT_IDX_W)) u_slots (
    .clk(clk), .rst_n(rst_n), .da(da), .slot_valid(slot_valid), .slot_addr(slot_addr),
    .hit_any(hit_any), .hit_idx(hit_idx)
  );

  da_hash_gate #(.ADDR_W(DA_W), .HASH_IDX_W(HASH_IDX_W)) u_hash (
    .clk(clk), .rst_n(rst_n), .wr_en(hash_wr), .wr_idx(hash_idx), .wr_bit(hash_bit),
    .da(da), .mcast_en(opts_q.mcast_en),
    .is_bcast(is_bcast), .is_mcast(is_mcast), .hash_hit(hash_hit)
  );

  assign accept_now = opts_q.promisc || hit_any || (is_bcast && opts_q.bcast_en) || hash_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid    <= 1'b0;
      dec_accept   <= 1'b0;
      dec_slot_hit <= 1'b0;
      dec_slot_idx <= '0;
      dec_is_bcast <= 1'b0;
      dec_is_mcast <= 1'b0;
    end else begin
      dec_valid <= da_full;
      if (da_full) begin
        dec_accept   <= accept_now;
        dec_slot_hit <= hit_any;
        dec_slot_idx <= hit_idx;
        dec_is_bcast <= is_bcast;
        dec_is_mcast <= is_mcast;
      end
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |=> !dec_valid); // R2
  AST_PROMISC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (da_full && opts_q.promisc) |=> dec_accept); // R6
  AST_BCAST_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (da_full && is_bcast && !opts_q.bcast_en && !opts_q.promisc && !hit_any) |=> !dec_accept); // R7
  AST_HIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && dec_slot_hit) |-> dec_accept); // R4
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> !(dec_is_bcast && dec_is_mcast)); // R8
endmodule

// File: tb/eth_da_filter_bench.sv
module eth_da_filter_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready;
  logic opt_load = 1'b0, opt_promisc = 1'b0, opt_bcast = 1'b0, opt_mcast = 1'b0;
  logic hash_wr = 1'b0, hash_bit = 1'b0;
  logic [5:0] hash_idx = '0;
  logic [3:0] slot_valid = '0;
  logic [191:0] slot_addr = '0;
  logic dec_valid, dec_accept, dec_slot_hit, dec_is_bcast, dec_is_mcast;
  logic [1:0] dec_slot_idx;

  int n_chk = 0;
  int n_bad = 0;

  bit m_promisc = 1'b0, m_bcast = 1'b1, m_mcast = 1'b0;
  bit m_hash [64];

  always #5 clk = ~clk;

  eth_da_filter u_eth_da_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof),
    .in_data(in_data), .opt_load(opt_load), .opt_promisc(opt_promisc), .opt_bcast(opt_bcast),
    .opt_mcast(opt_mcast), .hash_wr(hash_wr), .hash_idx(hash_idx), .hash_bit(hash_bit),
    .slot_valid(slot_valid), .slot_addr(slot_addr), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_slot_hit(dec_slot_hit), .dec_slot_idx(dec_slot_idx),
    .dec_is_bcast(dec_is_bcast), .dec_is_mcast(dec_is_mcast)
  );

  task automatic check(string req, string what, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  function automatic logic [5:0] fold6(logic [47:0] a);
    logic [5:0] r = '0;
    for (int k = 0; k < 48; k++) r[k % 6] = r[k % 6] ^ a[k];
    return r;
  endfunction

  function automatic int model_slot(logic [47:0] a);
    for (int s = 0; s < 4; s++) begin
      if (slot_valid[s] && slot_addr[s*48 +: 48] != 48'h0 && slot_addr[s*48 +: 48] == a) return s;
    end
    return -1;
  endfunction

  function automatic bit model_accept(logic [47:0] a);
    bit bc = (a == {48{1'b1}});
    bit mc = a[0] && !bc;
    return m_promisc || (model_slot(a) >= 0) || (bc && m_bcast) || (mc && m_mcast && m_hash[fold6(a)]);
  endfunction

  task automatic push(bit sof, logic [7:0] d);
    in_valid = 1'b1; in_sof = sof; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
  endtask

  task automatic idle(int n);
    in_valid = 1'b0; in_sof = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_and_check(string req, logic [47:0] a, bit gaps);
    int sl;
    for (int k = 0; k < 6; k++) begin
      if (k == 5) check("R2", "early strobe", dec_valid, 0);
      push(k == 0, a[k*8 +: 8]);
      if (gaps && k < 5) idle(1);
    end
    sl = model_slot(a);
    check("R2", "strobe", dec_valid, 1);
    check(req, "accept", dec_accept, model_accept(a));
    check(req, "slot_hit", dec_slot_hit, sl >= 0);
    check(req, "slot_idx", dec_slot_idx, (sl >= 0) ? sl : 0);
    check(req, "is_bcast", dec_is_bcast, a == {48{1'b1}});
    check(req, "is_mcast", dec_is_mcast, a[0] && a != {48{1'b1}});
    idle(1);
    check("R2", "strobe drop", dec_valid, 0);
  endtask

  task automatic load_opts(bit p, bit b, bit m);
    opt_load = 1'b1; opt_promisc = p; opt_bcast = b; opt_mcast = m;
    @(negedge clk);
    opt_load = 1'b0;
    m_promisc = p; m_bcast = b; m_mcast = m;
  endtask

  task automatic write_hash(logic [5:0] i, bit v);
    hash_wr = 1'b1; hash_idx = i; hash_bit = v;
    @(negedge clk);
    hash_wr = 1'b0;
    m_hash[i] = v;
  endtask

  task automatic t_reset();
    check("R2", "reset strobe", dec_valid, 0);
    check("R11", "ready", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11", "ready after reset", in_ready, 1);
  endtask

  task automatic t_defaults();
    send_and_check("R7", {48{1'b1}}, 1'b0);
    check("R10", "bcast on after reset", dec_accept, 1);
    send_and_check("R8", 48'h0000_0000_5e01, 1'b0);
    check("R10", "mcast off after reset", dec_accept, 0);
    load_opts(1'b0, 1'b1, 1'b1);
    send_and_check("R9", 48'h0000_0000_5e01, 1'b0);
    check("R9", "table empty after reset", dec_accept, 0);
  endtask

  task automatic t_exact();
    slot_addr[0*48 +: 48] = 48'h1111_2222_3302;
    slot_addr[1*48 +: 48] = 48'h0a0b_0c0d_0e10;
    slot_addr[2*48 +: 48] = 48'h5566_7788_9a02;
    slot_addr[3*48 +: 48] = 48'h5566_7788_9a02;
    slot_valid = 4'b1110;
    idle(1);
    send_and_check("R4", 48'h5566_7788_9a02, 1'b0);
    check("R4", "lowest slot", dec_slot_idx, 2);
    send_and_check("R4", 48'h0a0b_0c0d_0e10, 1'b1);
    send_and_check("R5", 48'h1111_2222_3302, 1'b0);
    check("R5", "invalid slot rejects", dec_accept, 0);
    send_and_check("R12", 48'hdead_beef_0042, 1'b0);
    check("R12", "miss rejected", dec_accept, 0);
  endtask

  task automatic t_zero_slot();
    slot_addr[0*48 +: 48] = 48'h0;
    slot_valid = 4'b0001;
    idle(1);
    send_and_check("R5", 48'h0, 1'b0);
    check("R5", "zero slot off", dec_slot_hit, 0);
  endtask

  task automatic t_promisc();
    load_opts(1'b1, 1'b0, 1'b0);
    send_and_check("R6", 48'h1234_5678_9a00, 1'b0);
    check("R6", "promisc accept", dec_accept, 1);
    load_opts(1'b0, 1'b0, 1'b0);
    send_and_check("R7", {48{1'b1}}, 1'b0);
    check("R7", "bcast gated off", dec_accept, 0);
  endtask

  task automatic t_hash();
    logic [47:0] a = 48'h4433_2211_00a1;
    logic [5:0] ix = fold6(a);
    load_opts(1'b0, 1'b1, 1'b1);
    write_hash(ix, 1'b1);
    write_hash(ix ^ 6'h01, 1'b1);
    send_and_check("R8", a, 1'b0);
    check("R8", "hash pass", dec_accept, 1);
    write_hash(ix ^ 6'h01, 1'b0);
    send_and_check("R9", a, 1'b1);
    check("R9", "neighbour cleared only", dec_accept, 1);
    write_hash(ix, 1'b0);
    send_and_check("R9", a, 1'b0);
    check("R9", "own entry cleared", dec_accept, 0);
    write_hash(ix, 1'b1);
    load_opts(1'b0, 1'b1, 1'b0);
    send_and_check("R8", a, 1'b0);
    check("R8", "mcast disabled", dec_accept, 0);
  endtask

  task automatic t_stream_rules();
    push(1'b0, 8'h55);
    push(1'b0, 8'h66);
    idle(2);
    check("R1", "no start no strobe", dec_valid, 0);
    send_and_check("R1", 48'hfedc_ba98_7602, 1'b1);
    for (int k = 0; k < 8; k++) push(1'b0, 8'hff);
    idle(1);
    check("R1", "trailing bytes ignored", dec_valid, 0);
    push(1'b1, 8'hff);
    push(1'b0, 8'hff);
    push(1'b0, 8'hff);
    check("R3", "partial no strobe", dec_valid, 0);
    slot_addr[1*48 +: 48] = 48'h0a0b_0c0d_0e10;
    slot_valid = 4'b0010;
    send_and_check("R3", 48'h0a0b_0c0d_0e10, 1'b0);
    check("R3", "restart uses new octets", dec_slot_idx, 1);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m_hash[i] = 1'b0;
    idle(3);
    t_reset();
    t_defaults();
    t_exact();
    t_zero_slot();
    t_promisc();
    t_hash();
    t_stream_rules();
    idle(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule